// File: doc/BRIEF.md
# Integer Compare-and-Set Unit

This unit evaluates one integer comparison per accepted operation and delivers a single-bit verdict to one of two places: a sticky status flag (`t_bit`) held inside the unit, or a general register write carrying 0 or 1. The supported tests cover equality, inequality, signed and unsigned ordering, and bit tests. Less-than and less-or-equal are never computed directly. The issuing logic requests them by setting `in_swap`, which exchanges the two operands ahead of a greater-than or greater-or-equal test.

Two instruction shapes exist. The two-operand shape tests the second operand against the first and only touches the flag. A configuration input can switch this shape off, and it is then reported as illegal. The three-operand shape tests the first source against the second and writes the verdict to the named destination. If that destination is register zero, the verdict goes to the flag instead.

Operations enter through a valid/ready port and results leave through a valid/ready port. The unit has a single output register. `in_ready` is high whenever that register is empty or is being drained in the same cycle. A result held while `out_ready` is low stays unchanged, and no new operation is taken during that time. Register writes are not performed here: the write enable, index and data are reported as part of each result.

Top module: `cmp_set_unit`

## Requirements
- R1: `in_op` encodes the test as follows: 0 equal, 1 not equal, 4 unsigned higher, 5 unsigned higher-or-same, 6 bit-test (true when the AND of the two operands is nonzero), 7 inverted bit-test (true when that AND is zero).
- R2: Op 2 (signed greater-than) and op 3 (signed greater-or-equal) use 64-bit two's-complement ordering. The most negative value is ordered below every other value.
- R3: Ops 4 and 5 compare all 64 bits as unsigned magnitudes.
- R4: With `in_three_op`=0 and `cfg_two_op_en`=1, the test is `in_src2` OP `in_src1`. The verdict is loaded into `t_bit` and the result has `out_wr_en`=0.
- R5: With `in_three_op`=1 and `in_dst`≠0, the test is `in_src1` OP `in_src2`. The result has `out_wr_en`=1, `out_wr_idx`=`in_dst` and `out_wr_data` equal to 1 or 0. `t_bit` is unchanged.
- R6: With `in_three_op`=1 and `in_dst`=0, the verdict is loaded into `t_bit` and the result has `out_wr_en`=0.
- R7: `in_swap`=1 exchanges the two operands before the test in either shape. This is how less-than and less-or-equal are obtained.
- R8: A two-operand operation with `cfg_two_op_en`=0 produces a result with `out_illegal`=1 and `out_wr_en`=0, and leaves `t_bit` unchanged.
- R9: An operation is accepted when `in_valid` and `in_ready` are both high. Its result appears on the next cycle with `out_valid`=1, and `t_bit` updates on that same edge. `in_ready` equals `!out_valid || out_ready`. A result held under back-pressure stays stable.
- R10: Synchronous `rst` clears `out_valid` and `t_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_two_op_en | input | 1 | Allows the two-operand flag-only shape |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 3 | Test select |
| in_swap | input | 1 | Exchange operands before the test |
| in_three_op | input | 1 | 1 = three-operand shape, 0 = two-operand shape |
| in_src1 | input | 64 | First operand |
| in_src2 | input | 64 | Second operand |
| in_dst | input | 5 | Destination register index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken by the consumer |
| out_wr_en | output | 1 | Result requests a register write |
| out_wr_idx | output | 5 | Register index to write |
| out_wr_data | output | 64 | Value to write (0 or 1) |
| out_illegal | output | 1 | Operation refused as illegal |
| t_bit | output | 1 | Status flag |

## Verification
Two events can share one clock edge. A new operation is accepted and rewrites `t_bit`, and on that same edge the previous result leaves under `out_ready`. The bench provokes this by toggling `out_ready` in a periodic pattern while it issues operations back to back, so that some acceptances line up with a stall being released. Each scoreboard entry records the flag value expected while its result is on the port. A flag that moves early, or a result that changes while held, shows up as a mismatch on the entry that is being drained.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    TST_EQ   = 3'd0,
    TST_NE   = 3'd1,
    TST_SGT  = 3'd2,
    TST_SGE  = 3'd3,
    TST_UGT  = 3'd4,
    TST_UGE  = 3'd5,
    TST_AND  = 3'd6,
    TST_NAND = 3'd7
  } cmp_op_e;

  typedef enum logic [1:0] {
    SINK_NONE = 2'd0,
    SINK_FLAG = 2'd1,
    SINK_REG  = 2'd2,
    SINK_BAD  = 2'd3
  } cmp_sink_e;
endpackage

// File: rtl/cmp_order.sv
module cmp_order #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              three_op,
  input  logic              swap,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  output logic [DATA_W-1:0] lhs,
  output logic [DATA_W-1:0] rhs
);
  logic [DATA_W-1:0] nat_l, nat_r;

  // three-operand shape: src1 OP src2; two-operand shape: src2 OP src1
  always_comb begin
    nat_l = three_op ? src1 : src2;
    nat_r = three_op ? src2 : src1;
    lhs   = swap ? nat_r : nat_l;
    rhs   = swap ? nat_l : nat_r;
  end
endmodule

// File: rtl/cmp_eval.sv
module cmp_eval
  import cmp_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter bit          BIAS_CMP = 1'b1
) (
  input  cmp_op_e           op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              verdict
);
  localparam int unsigned MSB = DATA_W - 1;

  logic s_gt, s_eq, u_gt, eq, any_and;

  assign eq      = (lhs == rhs);
  assign u_gt    = (lhs > rhs);
  assign any_and = |(lhs & rhs);
  assign s_eq    = eq;

  generate
    if (BIAS_CMP) begin : g_bias
      // flip sign bits so that an unsigned compare gives two's-complement order
      logic [DATA_W-1:0] bl, br;
      assign bl   = {~lhs[MSB], lhs[MSB-1:0]};
      assign br   = {~rhs[MSB], rhs[MSB-1:0]};
      assign s_gt = (bl > br);
    end else begin : g_direct
      assign s_gt = ($signed(lhs) > $signed(rhs));
    end
  endgenerate

  always_comb begin
    unique case (op)
      TST_EQ:   verdict = eq;
      TST_NE:   verdict = !eq;
      TST_SGT:  verdict = s_gt;
      TST_SGE:  verdict = s_gt || s_eq;
      TST_UGT:  verdict = u_gt;
      TST_UGE:  verdict = u_gt || eq;
      TST_AND:  verdict = any_and;
      TST_NAND: verdict = !any_and;
      default:  verdict = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_steer.sv
module cmp_steer
  import cmp_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             three_op,
  input  logic             two_op_en,
  input  logic [IDX_W-1:0] dst,
  output cmp_sink_e        sink
);
  always_comb begin
    if (three_op)
      sink = (dst == '0) ? SINK_FLAG : SINK_REG;
    else
      sink = two_op_en ? SINK_FLAG : SINK_BAD;
  end
endmodule

// File: rtl/cmp_set_unit.sv
module cmp_set_unit
  import cmp_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned IDX_W    = 5,
  parameter bit          BIAS_CMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_two_op_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic              in_swap,
  input  logic              in_three_op,
  input  logic [DATA_W-1:0] in_src1,
  input  logic [DATA_W-1:0] in_src2,
  input  logic [IDX_W-1:0]  in_dst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wr_en,
  output logic [IDX_W-1:0]  out_wr_idx,
  output logic [DATA_W-1:0] out_wr_data,
  output logic              out_illegal,
  output logic              t_bit
);
  logic [DATA_W-1:0] lhs, rhs;
  logic              verdict;
  cmp_sink_e         sink;
  logic              take;

  cmp_order #(.DATA_W(DATA_W)) u_order (
    .three_op(in_three_op), .swap(in_swap),
    .src1(in_src1), .src2(in_src2), .lhs(lhs), .rhs(rhs)
  );

  cmp_eval #(.DATA_W(DATA_W), .BIAS_CMP(BIAS_CMP)) u_eval (
    .op(cmp_op_e'(in_op)), .lhs(lhs), .rhs(rhs), .verdict(verdict)
  );

  cmp_steer #(.IDX_W(IDX_W)) u_steer (
    .three_op(in_three_op), .two_op_en(cfg_two_op_en),
    .dst(in_dst), .sink(sink)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_wr_en   <= 1'b0;
      out_wr_idx  <= '0;
      out_wr_data <= '0;
      out_illegal <= 1'b0;
      t_bit       <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_wr_en   <= (sink == SINK_REG);
        out_wr_idx  <= in_dst;
        out_wr_data <= {{(DATA_W-1){1'b0}}, verdict};
        out_illegal <= (sink == SINK_BAD);
        if (sink == SINK_FLAG)
          t_bit <= verdict;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_wr_data) && $stable(out_wr_en) && $stable(out_illegal)); // R9
  AST_FLAG_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(t_bit)); // R9
  AST_REG_WRITE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_three_op && in_dst != '0 |=> $stable(t_bit) && out_wr_en); // R5
  AST_NO_WRITE_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_wr_en |-> out_wr_idx != '0); // R6
  AST_BOOLEAN_DATA: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_wr_en |-> out_wr_data[DATA_W-1:1] == '0); // R5
  AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !in_three_op && !cfg_two_op_en |=> $stable(t_bit) && out_illegal && !out_wr_en); // R8
  AST_TWO_OP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !in_three_op |=> !out_wr_en); // R4
endmodule

// File: tb/tb_cmp_set_unit.sv
module tb_cmp_set_unit;
  localparam int W = 64;
  localparam logic [W-1:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [W-1:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [W-1:0] ALL1 = '1;

  typedef struct {
    logic       wr_en;
    logic [4:0] idx;
    logic       data;
    logic       illegal;
    logic       t;
    string      tag;
  } item_t;

  logic clk = 1'b0, rst = 1'b1, cfg_two_op_en = 1'b1;
  logic in_valid = 1'b0, in_swap = 1'b0, in_three_op = 1'b0;
  logic [2:0] in_op = '0;
  logic [W-1:0] in_src1 = '0, in_src2 = '0;
  logic [4:0] in_dst = '0;
  logic in_ready, out_valid, out_ready, out_wr_en, out_illegal, t_bit;
  logic [4:0] out_wr_idx;
  logic [W-1:0] out_wr_data;
  logic bp_on = 1'b0;
  logic [2:0] cyc = '0;
  logic exp_t = 1'b0;
  int checks = 0, errors = 0, wd = 0;
  item_t sb[$];

  always #10 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 3'd1;
  assign out_ready = !bp_on || cyc[1];

  cmp_set_unit dut (.*);

  function automatic logic model(input logic [2:0] op, input logic [W-1:0] l, input logic [W-1:0] r);
    case (op)
      3'd0: return l == r;
      3'd1: return l != r;
      3'd2: return $signed(l) > $signed(r);
      3'd3: return $signed(l) >= $signed(r);
      3'd4: return l > r;
      3'd5: return l >= r;
      3'd6: return (l & r) != 0;
      default: return (l & r) == 0;
    endcase
  endfunction

  task automatic issue(input string tag, input logic [2:0] op, input logic three, input logic sw,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic [4:0] d);
    item_t it;
    logic [W-1:0] l, r, tmp;
    logic v;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_three_op = three; in_swap = sw;
    in_src1 = a; in_src2 = b; in_dst = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    l = three ? a : b; r = three ? b : a;
    if (sw) begin tmp = l; l = r; r = tmp; end
    v = model(op, l, r);
    it.tag = tag; it.idx = d; it.data = 1'b0; it.wr_en = 1'b0; it.illegal = 1'b0;
    if (!three && !cfg_two_op_en) it.illegal = 1'b1;
    else if (three && d != 0) begin it.wr_en = 1'b1; it.data = v; end
    else exp_t = v;
    it.t = exp_t;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 1'b0;
  endtask

  // monitor: a result is consumed at the edge after a negedge seeing valid && ready
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      item_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++; $display("FAIL R9 unexpected result wr_en=%0b", out_wr_en);
      end else begin
        e = sb.pop_front();
        if (out_wr_en !== e.wr_en || out_illegal !== e.illegal || t_bit !== e.t ||
            (e.wr_en && (out_wr_idx !== e.idx || out_wr_data !== {63'd0, e.data}))) begin
          errors++;
          $display("FAIL %s got wr_en=%0b idx=%0d data=%0h ill=%0b t=%0b exp wr_en=%0b idx=%0d data=%0b ill=%0b t=%0b",
                   e.tag, out_wr_en, out_wr_idx, out_wr_data, out_illegal, t_bit,
                   e.wr_en, e.idx, e.data, e.illegal, e.t);
        end
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || t_bit !== 1'b0 || in_ready !== 1'b1) begin
      errors++; $display("FAIL R10 reset state v=%0b t=%0b rdy=%0b exp 0 0 1", out_valid, t_bit, in_ready);
    end
    rst = 1'b0;
    // R1 equality and bit tests, three-operand register writes
    issue("R1_eq_true",  3'd0, 1, 0, 64'h1234, 64'h1234, 5'd3);
    issue("R1_eq_false", 3'd0, 1, 0, 64'h1234, 64'h1235, 5'd3);
    issue("R1_ne",       3'd1, 1, 0, 64'h5, 64'h6, 5'd7);
    issue("R1_tst_hit",  3'd6, 1, 0, 64'hF0, 64'h10, 5'd9);
    issue("R1_tst_miss", 3'd6, 1, 0, 64'hF0, 64'h0F, 5'd9);
    issue("R1_ntst",     3'd7, 1, 0, 64'hF0, 64'h0F, 5'd31);
    // R2 signed ordering
    issue("R2_min_lt_max", 3'd2, 1, 0, MINV, MAXV, 5'd4);
    issue("R2_max_gt_min", 3'd2, 1, 0, MAXV, MINV, 5'd4);
    issue("R2_neg1_gt_min", 3'd2, 1, 0, ALL1, MINV, 5'd4);
    issue("R2_ge_equal",  3'd3, 1, 0, MINV, MINV, 5'd4);
    // R3 unsigned ordering
    issue("R3_hi_all1",  3'd4, 1, 0, ALL1, 64'd1, 5'd5);
    issue("R3_hi_msb",   3'd4, 1, 0, 64'd1, MINV, 5'd5);
    issue("R3_hs_eq",    3'd5, 1, 0, ALL1, ALL1, 5'd5);
    // R6 zero destination sets the flag
    issue("R6_flag_set", 3'd0, 1, 0, 64'd8, 64'd8, 5'd0);
    issue("R5_keeps_flag", 3'd1, 1, 0, 64'd8, 64'd8, 5'd2);
    issue("R6_flag_clr", 3'd4, 1, 0, 64'd1, 64'd2, 5'd0);
    // R4 two-operand: src2 > src1
    issue("R4_two_op_gt", 3'd2, 0, 0, 64'd3, 64'd9, 5'd6);
    issue("R4_two_op_ngt", 3'd2, 0, 0, 64'd9, 64'd3, 5'd6);
    issue("R4_two_op_hi", 3'd4, 0, 0, 64'd1, ALL1, 5'd6);
    // R7 swapped forms (less-than / less-or-equal)
    issue("R7_slt",  3'd2, 1, 1, MINV, 64'd0, 5'd10);
    issue("R7_sle",  3'd3, 1, 1, 64'd4, 64'd4, 5'd10);
    issue("R7_sltu", 3'd4, 1, 1, 64'd0, MINV, 5'd10);
    issue("R7_two_op_swap", 3'd2, 0, 1, 64'd9, 64'd3, 5'd0);
    // R8 disabled two-operand shape
    issue("R8_set_flag", 3'd0, 1, 0, 64'd1, 64'd1, 5'd0);
    idle();
    cfg_two_op_en = 1'b0;
    issue("R8_illegal", 3'd1, 0, 0, 64'd1, 64'd1, 5'd1);
    issue("R8_three_ok", 3'd1, 1, 0, 64'd1, 64'd2, 5'd1);
    idle();
    cfg_two_op_en = 1'b1;
    // R9 back-pressure while issuing back to back
    bp_on = 1'b1;
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] a, b;
      a = {32'(i * 977), 32'(i * 31)} ^ (i[0] ? MINV : 64'd0);
      b = {32'(i * 13), 32'(i * 40503)};
      issue("R9_stream", 3'(i), 1'(i % 3 != 0), 1'(i[1]), a, b, 5'(i % 4));
    end
    idle();
    bp_on = 1'b0;
    repeat (10) @(negedge clk);
    checks++;
    if (sb.size() != 0 || out_valid !== 1'b0) begin
      errors++; $display("FAIL R9 drain left=%0d out_valid=%0b exp 0 0", sb.size(), out_valid);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule